// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a chip between four power states and drives the control lines of every power domain for each of them. In the normal state everything is powered and clocked. A stop request moves the chip to a retention state: the domains that can keep their flip-flops save them and have their clocks cut. A deep-stop request goes one step further. The domains that cannot retain state are isolated, and their internal power switches are then opened. A sleep request goes further again and turns off the external regulator as well. Only the always-on logic and the real-time clock keep their state there.

A wake-up event in any resting low-power state runs the entry steps backwards. The regulator comes back first if it was off. The switches close next and their settling is awaited. Isolation is then released, retained state is restored, and clocks return last. Two counters time the settle windows. The internal switch settles faster than the regulator, so its window is the shorter of the two. Both lengths are parameters given in clock cycles.

Top module: `pwr_mode_seq`

## Requirements
- R1: `state_code` reports the resting state: 2'b00 normal, 2'b01 retention, 2'b10 power gating, 2'b11 power off. Request modes on `req_mode` are 2'b00 run, 2'b01 stop, 2'b10 deep-stop and 2'b11 sleep, and they lead to codes 01, 10 and 11 respectively. The code changes only when a resting state is reached, and it holds its old value throughout a transition. After reset it is 2'b00.
- R2: `reg_en` is low only while the regulator is going off or is off. It is never low while any domain switch is closed.
- R3: Every bit of `keep_en` is raised at least one cycle before `clk_en` falls. It stays high in all three low-power states.
- R4: In retention the non-retention domains stay powered and unisolated. In power gating and power off, all of their `sw_en` bits are low and all of their `iso_en` bits are high.
- R5: `iso_en` is raised at least one cycle before `sw_en` falls.
- R6: On entry, `reg_en` falls exactly SW_SETTLE cycles after `sw_en` falls, or the power-gating rest is reached at that point. The power-off rest is reached exactly REG_SETTLE cycles after `reg_en` falls. SW_SETTLE must be smaller than REG_SETTLE.
- R7: On exit from power off, `sw_en` rises exactly REG_SETTLE cycles after `reg_en` rises. On exit from power gating or power off, `iso_en` falls exactly SW_SETTLE cycles after `sw_en` rises.
- R8: On every exit, `restore` pulses high for exactly one cycle. The pulse comes after isolation is released and while power is on, one cycle before `clk_en` rises and the normal state is reached.
- R9: Mode requests are accepted only in the resting normal state, and a run request there has no effect. Wake-up is honoured only in a resting low-power state. Both are ignored at all other times, including during every transition.
- R10: `busy` is high exactly during transitions. Entry takes 2 cycles for stop, SW_SETTLE+3 for deep-stop and SW_SETTLE+REG_SETTLE+3 for sleep. Exit takes 2 cycles from retention, SW_SETTLE+3 from power gating and REG_SETTLE+SW_SETTLE+3 from power off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 0 run, 1 stop, 2 deep-stop, 3 sleep |
| wake | input | 1 | Wake-up event |
| reg_en | output | 1 | External regulator enable |
| keep_en | output | NRET | Retention save hold, one per retainable domain |
| clk_en | output | NRET | Clock enable, one per retainable domain |
| restore | output | NRET | One-cycle state restore pulse, one per retainable domain |
| sw_en | output | NGATE | Internal power switch enable (1 = powered), one per non-retention domain |
| iso_en | output | NGATE | Output isolation, one per non-retention domain |
| state_code | output | 2 | Current resting power state |
| busy | output | 1 | Transition in progress |

## Verification
The hardest situation to reach from the ports is a request or wake-up that arrives in the middle of a multi-cycle settle window. It must be dropped there, and it must not be carried over into the resting state that follows. The stimulus covers this by driving random mode requests and wake pulses on random cycles while `busy` is high, during both entry and exit. Every mode is reached this way from a $urandom sequence with a fixed seed. Each run is timed edge by edge from the ports, and the measured gaps are compared with the settle parameters. After each run the resting outputs and the state code are checked, so a stray event that had been accepted would show up.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_STOP  = 2'd1,
    MODE_DEEP  = 2'd2,
    MODE_SLEEP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_RETAIN = 2'd1,
    ST_GATED  = 2'd2,
    ST_OFF    = 2'd3
  } pstate_e;

  // Sequencer phases: entry steps, resting points, exit steps.
  typedef enum logic [3:0] {
    PH_RUN, PH_SAVE, PH_CLKOFF, PH_RET, PH_ISO, PH_SWOFF, PH_GATE,
    PH_REGOFF, PH_OFF, PH_REGON, PH_SWON, PH_UNISO, PH_RESTORE, PH_CLKON
  } phase_e;

  typedef struct packed {
    logic reg_on;
    logic sw_on;
    logic iso_on;
    logic keep_on;
    logic clk_on;
    logic restore;
  } ctrl_t;

  // Decode of the control lines for each phase.
  function automatic ctrl_t phase_ctrl(phase_e ph);
    ctrl_t c;
    c.reg_on  = !(ph inside {PH_REGOFF, PH_OFF});
    c.sw_on   = !(ph inside {PH_SWOFF, PH_GATE, PH_REGOFF, PH_OFF, PH_REGON});
    c.iso_on  = ph inside {PH_ISO, PH_SWOFF, PH_GATE, PH_REGOFF, PH_OFF,
                           PH_REGON, PH_SWON};
    c.keep_on = ph inside {PH_SAVE, PH_CLKOFF, PH_RET, PH_ISO, PH_SWOFF,
                           PH_GATE, PH_REGOFF, PH_OFF, PH_REGON, PH_SWON,
                           PH_UNISO};
    c.clk_on  = ph inside {PH_RUN, PH_SAVE, PH_CLKON};
    c.restore = (ph == PH_RESTORE);
    return c;
  endfunction

  function automatic logic is_rest(phase_e ph);
    return ph inside {PH_RUN, PH_RET, PH_GATE, PH_OFF};
  endfunction

  function automatic pstate_e rest_code(phase_e ph);
    case (ph)
      PH_RET:  return ST_RETAIN;
      PH_GATE: return ST_GATED;
      PH_OFF:  return ST_OFF;
      default: return ST_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [W-1:0] LOAD = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run_q && (cnt_q == '0);

  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && cnt_q != '0) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

  assert_done_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !run_q);

endmodule

// File: rtl/pwr_phase_fsm.sv
module pwr_phase_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake,
  input  logic       sw_done,
  input  logic       reg_done,
  output phase_e     phase,
  output logic       sw_start,
  output logic       reg_start,
  output logic [1:0] state_code,
  output logic       busy
);
  phase_e  phase_n;
  mode_e   target_q;
  pstate_e code_q;
  logic    accept;

  assign accept = req_valid && (req_mode != MODE_RUN);

  always_comb begin
    phase_n   = phase;
    sw_start  = 1'b0;
    reg_start = 1'b0;
    unique case (phase)
      PH_RUN:     if (accept) phase_n = PH_SAVE;
      PH_SAVE:    phase_n = PH_CLKOFF;
      PH_CLKOFF:  phase_n = (target_q == MODE_STOP) ? PH_RET : PH_ISO;
      PH_RET:     if (wake) phase_n = PH_RESTORE;
      PH_ISO: begin
        phase_n  = PH_SWOFF;
        sw_start = 1'b1;
      end
      PH_SWOFF: if (sw_done) begin
        if (target_q == MODE_DEEP) phase_n = PH_GATE;
        else begin
          phase_n   = PH_REGOFF;
          reg_start = 1'b1;
        end
      end
      PH_GATE: if (wake) begin
        phase_n  = PH_SWON;
        sw_start = 1'b1;
      end
      PH_REGOFF:  if (reg_done) phase_n = PH_OFF;
      PH_OFF: if (wake) begin
        phase_n   = PH_REGON;
        reg_start = 1'b1;
      end
      PH_REGON: if (reg_done) begin
        phase_n  = PH_SWON;
        sw_start = 1'b1;
      end
      PH_SWON:    if (sw_done) phase_n = PH_UNISO;
      PH_UNISO:   phase_n = PH_RESTORE;
      PH_RESTORE: phase_n = PH_CLKON;
      PH_CLKON:   phase_n = PH_RUN;
      default:    phase_n = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_RUN;
      target_q <= MODE_RUN;
      code_q   <= ST_NORMAL;
    end else begin
      phase <= phase_n;
      if (phase == PH_RUN && accept) target_q <= mode_e'(req_mode);
      if (phase_n != phase && is_rest(phase_n)) code_q <= rest_code(phase_n);
    end
  end

  assign state_code = code_q;
  assign busy       = !is_rest(phase);

  assert_code_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(state_code));

  assert_rest_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN && !busy && !wake) |=> !busy);

endmodule

// File: rtl/pwr_domain_fanout.sv
module pwr_domain_fanout
  import pwr_mode_pkg::*;
#(
  parameter int NRET  = 3,
  parameter int NGATE = 5
) (
  input  ctrl_t            ctl,
  output logic [NRET-1:0]  keep_en,
  output logic [NRET-1:0]  clk_en,
  output logic [NRET-1:0]  restore,
  output logic [NGATE-1:0] sw_en,
  output logic [NGATE-1:0] iso_en
);
  for (genvar i = 0; i < NRET; i++) begin : g_ret
    assign keep_en[i] = ctl.keep_on;
    assign clk_en[i]  = ctl.clk_on;
    assign restore[i] = ctl.restore;
  end

  for (genvar j = 0; j < NGATE; j++) begin : g_gate
    assign sw_en[j]  = ctl.sw_on;
    assign iso_en[j] = ctl.iso_on;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int NRET       = 3,
  parameter int NGATE      = 5,
  parameter int SW_SETTLE  = 8,
  parameter int REG_SETTLE = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             wake,
  output logic             reg_en,
  output logic [NRET-1:0]  keep_en,
  output logic [NRET-1:0]  clk_en,
  output logic [NRET-1:0]  restore,
  output logic [NGATE-1:0] sw_en,
  output logic [NGATE-1:0] iso_en,
  output logic [1:0]       state_code,
  output logic             busy
);
  if (SW_SETTLE < 1 || SW_SETTLE >= REG_SETTLE) begin : g_bad_settle
    $error("switch settle must be at least 1 and below regulator settle");
  end

  phase_e phase;
  ctrl_t  ctl;
  logic   sw_start, reg_start, sw_done, reg_done;

  pwr_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .wake       (wake),
    .sw_done    (sw_done),
    .reg_done   (reg_done),
    .phase      (phase),
    .sw_start   (sw_start),
    .reg_start  (reg_start),
    .state_code (state_code),
    .busy       (busy)
  );

  pwr_settle_timer #(.CYCLES(SW_SETTLE)) u_sw_timer (
    .clk(clk), .rst_n(rst_n), .start(sw_start), .done(sw_done)
  );

  pwr_settle_timer #(.CYCLES(REG_SETTLE)) u_reg_timer (
    .clk(clk), .rst_n(rst_n), .start(reg_start), .done(reg_done)
  );

  assign ctl    = phase_ctrl(phase);
  assign reg_en = ctl.reg_on;

  pwr_domain_fanout #(.NRET(NRET), .NGATE(NGATE)) u_fanout (
    .ctl     (ctl),
    .keep_en (keep_en),
    .clk_en  (clk_en),
    .restore (restore),
    .sw_en   (sw_en),
    .iso_en  (iso_en)
  );

  assert_reg_off_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (sw_en == '0 && iso_en == '1));

  assert_save_before_clkoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.clk_on) |-> ($past(ctl.keep_on) && ctl.keep_on));

  assert_iso_before_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.sw_on) |-> $past(ctl.iso_on));

  assert_sw_settled_before_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.reg_on) |-> $past(sw_done));

  assert_iso_release_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.iso_on) |-> ($past(sw_done) && ctl.sw_on));

  assert_restore_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restore |-> (reg_en && ctl.sw_on && !ctl.iso_on && !ctl.clk_on));

  assert_clk_after_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.clk_on) |-> $past(ctl.restore));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int NRET = 3, NGATE = 5, SW = 8, REG = 40;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, wake = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic reg_en, busy;
  logic [NRET-1:0] keep_en, clk_en, restore;
  logic [NGATE-1:0] sw_en, iso_en;
  logic [1:0] state_code;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NRET(NRET), .NGATE(NGATE), .SW_SETTLE(SW), .REG_SETTLE(REG)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wake(wake), .reg_en(reg_en), .keep_en(keep_en), .clk_en(clk_en),
    .restore(restore), .sw_en(sw_en), .iso_en(iso_en),
    .state_code(state_code), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // Expected resting outputs per mode (0 run, 1 stop, 2 deep, 3 sleep).
  function automatic int exp_reg(int m);  return (m != 3) ? 1 : 0; endfunction
  function automatic int exp_sw(int m);   return (m < 2) ? (1 << NGATE) - 1 : 0; endfunction
  function automatic int exp_iso(int m);  return (m >= 2) ? (1 << NGATE) - 1 : 0; endfunction
  function automatic int exp_keep(int m); return (m != 0) ? (1 << NRET) - 1 : 0; endfunction
  function automatic int exp_clk(int m);  return (m == 0) ? (1 << NRET) - 1 : 0; endfunction
  function automatic int entry_len(int m);
    return (m == 1) ? 2 : (m == 2) ? SW + 3 : SW + REG + 3;
  endfunction
  function automatic int exit_len(int m);
    return (m == 1) ? 2 : (m == 2) ? SW + 3 : REG + SW + 3;
  endfunction

  task automatic check_rest(input int m);
    chk_eq("R1", "state_code", int'(state_code), m);
    chk_eq("R10", "busy at rest", int'(busy), 0);
    chk_eq("R2", "reg_en", int'(reg_en), exp_reg(m));
    chk_eq("R4", "sw_en", int'(sw_en), exp_sw(m));
    chk_eq("R4", "iso_en", int'(iso_en), exp_iso(m));
    chk_eq("R3", "keep_en", int'(keep_en), exp_keep(m));
    chk_eq("R3", "clk_en", int'(clk_en), exp_clk(m));
    chk_eq("R8", "restore at rest", int'(restore), 0);
  endtask

  task automatic noise(input bit en);
    if (en && busy && ($urandom % 3 == 0)) begin
      req_valid = 1'b1;
      req_mode  = 2'($urandom);
      wake      = $urandom % 2;
    end else begin
      req_valid = 1'b0;
      wake      = 1'b0;
    end
  endtask

  task automatic enter(input int m, input bit nz);
    int t_sw = -1, t_reg = -1, t_iso = -1, t_keep = -1, t_clk = -1, t_done = -1;
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = 2'(m);
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        chk_eq("R10", "busy after request", int'(busy), 1);
      end
      if (t_sw < 0 && sw_en != '1) t_sw = k;
      if (t_reg < 0 && !reg_en) t_reg = k;
      if (t_iso < 0 && iso_en != '0) t_iso = k;
      if (t_keep < 0 && keep_en != '0) t_keep = k;
      if (t_clk < 0 && clk_en != '1) t_clk = k;
      if (busy) chk_eq("R1", "code held on entry", int'(state_code), 0);
      if (!busy) begin
        req_valid = 1'b0;
        wake = 1'b0;
        t_done = k;
        break;
      end
      noise(nz);
    end
    req_valid = 1'b0;
    wake = 1'b0;
    chk_eq("R10", "entry length", t_done - 1, entry_len(m));
    chk(t_keep >= 0 && t_clk > t_keep, "R3", "save before clock gate", t_clk, t_keep + 1);
    if (m == 1) begin
      chk_eq("R4", "switch stays closed in retention", t_sw, -1);
    end else begin
      chk(t_iso >= 0 && t_iso < t_sw, "R5", "isolation before switch opens", t_iso, t_sw - 1);
      if (m == 2) chk_eq("R6", "switch settle to rest", t_done - t_sw, SW);
      else begin
        chk_eq("R6", "switch settle to reg off", t_reg - t_sw, SW);
        chk_eq("R6", "reg settle to rest", t_done - t_reg, REG);
      end
    end
    check_rest(m);
  endtask

  task automatic leave(input int m, input bit nz);
    int t_reg = -1, t_sw = -1, t_iso = -1, t_rst = -1, t_clk = -1, t_done = -1;
    int pulses = 0;
    @(negedge clk);
    wake = 1'b1;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (k == 1) wake = 1'b0;
      if (t_reg < 0 && m == 3 && reg_en) t_reg = k;
      if (t_sw < 0 && m >= 2 && sw_en == '1) t_sw = k;
      if (t_iso < 0 && m >= 2 && iso_en == '0) t_iso = k;
      if (restore == '1) begin
        pulses++;
        if (t_rst < 0) t_rst = k;
      end
      if (t_clk < 0 && clk_en == '1) t_clk = k;
      if (busy) chk_eq("R1", "code held on exit", int'(state_code), m);
      if (!busy) begin
        req_valid = 1'b0;
        wake = 1'b0;
        t_done = k;
        break;
      end
      noise(nz);
    end
    req_valid = 1'b0;
    wake = 1'b0;
    chk_eq("R10", "exit length", t_done - 1, exit_len(m));
    chk_eq("R8", "restore pulse width", pulses, 1);
    chk_eq("R8", "restore one cycle before clocks", t_clk - t_rst, 1);
    if (m == 3) chk_eq("R7", "reg settle before switch", t_sw - t_reg, REG);
    if (m >= 2) begin
      chk_eq("R7", "switch settle before iso release", t_iso - t_sw, SW);
      chk(t_rst > t_iso, "R8", "restore after iso release", t_rst, t_iso + 1);
    end
    check_rest(0);
  endtask

  // Stimulus that must be ignored in a resting state.
  task automatic poke_rest(input int m);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (m == 0) begin
        wake = 1'b1;
        req_valid = (k == 3);
        req_mode = 2'd0;
      end else begin
        req_valid = 1'b1;
        req_mode = 2'($urandom);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    wake = 1'b0;
    @(negedge clk);
    chk_eq("R9", "rest ignores stray input", int'(busy), 0);
    check_rest(m);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_0b7a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_rest(0);                    // R1 reset state
    poke_rest(0);                     // R9 wake and run request in normal
    for (int m = 1; m <= 3; m++) begin
      enter(m, 1'b0);
      poke_rest(m);
      leave(m, 1'b0);
    end
    for (int i = 0; i < 25; i++) begin
      int m = 1 + int'($urandom % 3);
      enter(m, 1'b1);
      if ($urandom % 2 == 0) poke_rest(m);
      repeat ($urandom % 5) @(negedge clk);
      leave(m, 1'b1);
      repeat ($urandom % 5) @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule